// File: doc/BRIEF.md
# Programmable Vertical-Blanking and Field Flag Generator

This block produces the two slow timing flags of a digital component video stream: V, which marks vertical blanking, and F, which marks the field. A line counter advances once for each line-start strobe and returns to zero at the end of each field. Every flag edge (V rising, V falling, F toggling) is placed at a programmed line offset from that return to zero.

Two complete edge programs are presented at the inputs, one for 525-line and one for 625-line timing. A standard-select input chooses between them. Each edge can be pushed back by one extra line. The extra line is enabled separately for even and odd fields.

The active program, the active standard and the field parity are captured only when the counter returns to zero. Host writes or a standard switch in mid-field therefore never split a field. The block's output registers feed timing-code insertion logic downstream.

Top module: `vf_flag_gen`

## Requirements
- R1: While `rst_n` is low (synchronous, sampled on `clk`), V and F are 0 and the line counter is 0. The first field after reset uses the built-in program for the standard on `std_625` during reset. For 525 lines that program is V set 5, V clear 4, F toggle 3. For 625 lines it is V set 5, V clear 20, F toggle 3. No delay bits are set in either.
- R2: The line counter advances by one on each `line_stb`. A field lasts 263 lines in 525 mode and 313 lines in 625 mode. The strobe that finds the counter at its last value (field length minus 1) is the rollover strobe and returns the counter to 0.
- R3: Each edge program byte has this layout: bits [4:0] hold the offset, bit 5 is the sign, bit 6 is the even-field delay and bit 7 is the odd-field delay. V becomes 1 on the strobe where the counter, read before it advances, equals the V-set target.
- R4: V becomes 0 on the strobe where the counter equals the V-clear target. When the clear target is below the set target, V stays high across the rollover until the clear target of the next field.
- R5: F inverts on the strobe where the counter equals the F-toggle target, and never otherwise.
- R6: An edge's target is its offset plus 1 when the delay bit for the current parity is set, and its offset otherwise. F = 0 is the even field and uses bit 6; F = 1 is the odd field and uses bit 7. Parity is taken from F at the rollover strobe and holds for the whole field.
- R7: The sign bit (bit 5) has no effect on any edge.
- R8: The program inputs and `std_625` are captured only on the rollover strobe. A change in mid-field has no effect until the following field.
- R9: Without `line_stb`, V, F and the counter hold their values.
- R10: When the V-set and V-clear targets fall on the same strobe, V ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_stb | input | 1 | One-cycle pulse at the start of each line |
| std_625 | input | 1 | 1 selects 625-line timing, 0 selects 525-line timing |
| cfg525_vset | input | 8 | 525-line V-set edge program |
| cfg525_vclr | input | 8 | 525-line V-clear edge program |
| cfg525_ftog | input | 8 | 525-line F-toggle edge program |
| cfg625_vset | input | 8 | 625-line V-set edge program |
| cfg625_vclr | input | 8 | 625-line V-clear edge program |
| cfg625_ftog | input | 8 | 625-line F-toggle edge program |
| v_flag | output | 1 | Vertical blanking flag |
| f_flag | output | 1 | Field flag |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Wrapped V interval.** With the clear offset below the set offset, a design that treats V as a window inside one field would drop V at rollover instead of holding it into the next field.
- **Delay bits.** Parity that follows the live F, rather than the F latched at rollover, moves odd-field edges by a line. Swapping the even and odd delay bits produces the same kind of shift.
- **Equal set and clear targets.** These expose a wrong priority, which leaves V high.
- **Sign bit.** Set sign bits reveal a design that folds the sign into the offset.
- **Mid-field changes.** A program or standard change in mid-field shows whether the design takes new values before rollover, which moves edges within the current field.
- **Reset with a non-default program.** Holding reset while a non-default program sits on the inputs checks that the first field runs on the built-in defaults.

// File: rtl/vf_pkg.sv
package vf_pkg;
   localparam int OFS_W  = 5;
   localparam int N_EDGE = 3;
   localparam int E_VSET = 0;
   localparam int E_VCLR = 1;
   localparam int E_FTOG = 2;

   typedef struct packed {
      logic             dly_odd;
      logic             dly_even;
      logic             sign;
      logic [OFS_W-1:0] ofs;
   } edge_cfg_t;

   typedef edge_cfg_t [N_EDGE-1:0] edge_set_t;
endpackage

// File: rtl/vf_line_counter.sv
module vf_line_counter #(
   parameter int LINES_A = 263,
   parameter int LINES_B = 313,
   parameter int CNT_W   = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_stb,
   input  logic             std_act,
   output logic [CNT_W-1:0] cnt,
   output logic             roll
);
   localparam logic [CNT_W-1:0] LAST_A = CNT_W'(LINES_A - 1);
   localparam logic [CNT_W-1:0] LAST_B = CNT_W'(LINES_B - 1);

   logic [CNT_W-1:0] last;

   assign last = std_act ? LAST_B : LAST_A;
   assign roll = line_stb && (cnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (roll)     cnt <= '0;
      else if (line_stb) cnt <= cnt + 1'b1;
   end

   assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last);
   assert_roll_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      roll |=> (cnt == '0));
   assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> $stable(cnt));
endmodule

// File: rtl/vf_cfg_shadow.sv
module vf_cfg_shadow
   import vf_pkg::*;
#(
   parameter edge_set_t DEF_A = '0,
   parameter edge_set_t DEF_B = '0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      roll,
   input  logic      std_sel,
   input  edge_set_t set_a,
   input  edge_set_t set_b,
   input  logic      f_now,
   output edge_set_t cfg,
   output logic      std_act,
   output logic      parity
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg     <= std_sel ? DEF_B : DEF_A;
         std_act <= std_sel;
         parity  <= 1'b0;
      end else if (roll) begin
         cfg     <= std_sel ? set_b : set_a;
         std_act <= std_sel;
         parity  <= f_now;
      end
   end

   assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !roll |=> ($stable(cfg) && $stable(std_act) && $stable(parity)));
endmodule

// File: rtl/vf_edge_match.sv
module vf_edge_match
   import vf_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  edge_cfg_t        cfg,
   input  logic             parity,
   input  logic [CNT_W-1:0] cnt,
   input  logic             line_stb,
   output logic             hit
);
   logic [OFS_W:0]   tgt;
   logic [CNT_W-1:0] tgt_w;
   logic             dly;
   logic             sign_unused;

   assign sign_unused = cfg.sign;
   assign dly         = parity ? cfg.dly_odd : cfg.dly_even;
   assign tgt         = {1'b0, cfg.ofs} + {{OFS_W{1'b0}}, dly};
   assign tgt_w       = CNT_W'(tgt);
   assign hit         = line_stb && (cnt == tgt_w);
endmodule

// File: rtl/vf_flag_gen.sv
module vf_flag_gen
   import vf_pkg::*;
#(
   parameter int LINES_525F   = 263,
   parameter int LINES_625F   = 313,
   parameter int DEF525_VSET  = 5,
   parameter int DEF525_VCLR  = 4,
   parameter int DEF525_FTOG  = 3,
   parameter int DEF625_VSET  = 5,
   parameter int DEF625_VCLR  = 20,
   parameter int DEF625_FTOG  = 3,
   parameter bit CLEAR_WINS   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_stb,
   input  logic       std_625,
   input  logic [7:0] cfg525_vset,
   input  logic [7:0] cfg525_vclr,
   input  logic [7:0] cfg525_ftog,
   input  logic [7:0] cfg625_vset,
   input  logic [7:0] cfg625_vclr,
   input  logic [7:0] cfg625_ftog,
   output logic       v_flag,
   output logic       f_flag
);
   localparam int MAX_LINES = (LINES_525F > LINES_625F) ? LINES_525F : LINES_625F;
   localparam int MIN_LINES = (LINES_525F < LINES_625F) ? LINES_525F : LINES_625F;
   localparam int CNT_W     = $clog2(MAX_LINES);
   localparam int MAX_TGT   = (1 << OFS_W);

   localparam edge_set_t DEF_A = edge_set_t'({8'(DEF525_FTOG), 8'(DEF525_VCLR), 8'(DEF525_VSET)});
   localparam edge_set_t DEF_B = edge_set_t'({8'(DEF625_FTOG), 8'(DEF625_VCLR), 8'(DEF625_VSET)});

   generate
      if (MIN_LINES <= MAX_TGT + 1) begin : g_bad_field_len
         $error("field length must exceed the largest edge target plus one");
      end
      if (CNT_W <= OFS_W) begin : g_bad_cnt_w
         $error("line counter narrower than an edge target");
      end
   endgenerate

   edge_set_t        set_a, set_b, cfg_act;
   logic             std_act, parity, roll;
   logic [CNT_W-1:0] cnt;
   logic [N_EDGE-1:0] hit;
   logic             v_nxt;

   assign set_a = edge_set_t'({cfg525_ftog, cfg525_vclr, cfg525_vset});
   assign set_b = edge_set_t'({cfg625_ftog, cfg625_vclr, cfg625_vset});

   vf_line_counter #(
      .LINES_A (LINES_525F),
      .LINES_B (LINES_625F),
      .CNT_W   (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_stb (line_stb),
      .std_act  (std_act),
      .cnt      (cnt),
      .roll     (roll)
   );

   vf_cfg_shadow #(
      .DEF_A (DEF_A),
      .DEF_B (DEF_B)
   ) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .roll    (roll),
      .std_sel (std_625),
      .set_a   (set_a),
      .set_b   (set_b),
      .f_now   (f_flag),
      .cfg     (cfg_act),
      .std_act (std_act),
      .parity  (parity)
   );

   generate
      for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
         vf_edge_match #(.CNT_W(CNT_W)) u_match (
            .cfg      (cfg_act[e]),
            .parity   (parity),
            .cnt      (cnt),
            .line_stb (line_stb),
            .hit      (hit[e])
         );
      end

      if (CLEAR_WINS) begin : g_clr_pri
         assign v_nxt = hit[E_VCLR] ? 1'b0 : (hit[E_VSET] ? 1'b1 : v_flag);
         assert_same_line_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            hit[E_VCLR] |=> !v_flag);
      end else begin : g_set_pri
         assign v_nxt = hit[E_VSET] ? 1'b1 : (hit[E_VCLR] ? 1'b0 : v_flag);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_flag <= 1'b0;
         f_flag <= 1'b0;
      end else begin
         v_flag <= v_nxt;
         if (hit[E_FTOG]) f_flag <= ~f_flag;
      end
   end

   assert_v_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> ($stable(v_flag) && $stable(f_flag)));
   assert_v_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[E_VSET] && !hit[E_VCLR]) |=> v_flag);
   assert_f_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit[E_FTOG] |=> (f_flag != $past(f_flag)));
   assert_f_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[E_FTOG] |=> $stable(f_flag));
   assert_one_edge_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
      roll |-> !hit[E_FTOG]);
endmodule

// File: tb/tb_vf_flag_gen.sv
`timescale 1ns/1ps
module tb_vf_flag_gen;
   localparam int LA = 263;
   localparam int LB = 313;

   typedef struct packed {
      logic       std;
      logic [7:0] vs;
      logic [7:0] vc;
      logic [7:0] ft;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{1'b0, 8'h08, 8'h0C, 8'h02},
      '{1'b0, 8'h4A, 8'h83, 8'hC0},
      '{1'b1, 8'h3F, 8'h3F, 8'h3F},
      '{1'b1, 8'h80, 8'h94, 8'h81},
      '{1'b0, 8'hDF, 8'h00, 8'h5F},
      '{1'b1, 8'h22, 8'h21, 8'h23}
   };

   logic       clk = 1'b0;
   logic       rst_n, line_stb, std_625;
   logic [7:0] c5_vs, c5_vc, c5_ft, c6_vs, c6_vc, c6_ft;
   logic       v_flag, f_flag;

   always #2 clk = ~clk;

   vf_flag_gen dut (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .std_625(std_625),
      .cfg525_vset(c5_vs), .cfg525_vclr(c5_vc), .cfg525_ftog(c5_ft),
      .cfg625_vset(c6_vs), .cfg625_vclr(c6_vc), .cfg625_ftog(c6_ft),
      .v_flag(v_flag), .f_flag(f_flag)
   );

   int n_vec = 0;
   int n_bad = 0;

   logic [7:0] m_cfg [3];
   logic       m_std, m_par, mv, mf;
   int         m_cnt;

   function automatic int tgt(logic [7:0] c, logic par);
      return int'(c[4:0]) + int'(par ? c[7] : c[6]);
   endfunction

   task automatic model_reset();
      m_std = std_625;
      m_cfg[0] = 8'd5;
      m_cfg[1] = std_625 ? 8'd20 : 8'd4;
      m_cfg[2] = 8'd3;
      m_par = 1'b0; mv = 1'b0; mf = 1'b0; m_cnt = 0;
   endtask

   task automatic model_step();
      if (m_cnt == tgt(m_cfg[0], m_par)) mv = 1'b1;
      if (m_cnt == tgt(m_cfg[1], m_par)) mv = 1'b0;
      if (m_cnt == tgt(m_cfg[2], m_par)) mf = ~mf;
      if (m_cnt == (m_std ? LB : LA) - 1) begin
         m_cnt = 0;
         m_std = std_625;
         m_cfg[0] = std_625 ? c6_vs : c5_vs;
         m_cfg[1] = std_625 ? c6_vc : c5_vc;
         m_cfg[2] = std_625 ? c6_ft : c5_ft;
         m_par = mf;
      end else begin
         m_cnt++;
      end
   endtask

   task automatic check(string tag);
      n_vec++;
      if (v_flag !== mv || f_flag !== mf) begin
         n_bad++;
         $display("FAIL %s: v=%0b f=%0b expected v=%0b f=%0b (line %0d)",
                  tag, v_flag, f_flag, mv, mf, m_cnt);
      end
   endtask

   task automatic strobe(string tag);
      @(negedge clk);
      line_stb = 1'b1;
      model_step();
      @(negedge clk);
      line_stb = 1'b0;
      check(tag);
   endtask

   task automatic do_reset(logic sel);
      @(negedge clk);
      rst_n = 1'b0; line_stb = 1'b0; std_625 = sel;
      repeat (3) @(negedge clk);
      model_reset();
      check("R1 reset state");
      rst_n = 1'b1;
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; line_stb = 1'b0; std_625 = 1'b0;
      c5_vs = 8'h00; c5_vc = 8'h00; c5_ft = 8'h00;
      c6_vs = 8'h00; c6_vc = 8'h00; c6_ft = 8'h00;
      do_reset(1'b0);

      // table walk: each vector runs three fields (R2 R3 R4 R5 R6 R7 R10)
      foreach (VEC[i]) begin
         std_625 = VEC[i].std;
         if (VEC[i].std) begin
            c6_vs = VEC[i].vs; c6_vc = VEC[i].vc; c6_ft = VEC[i].ft;
         end else begin
            c5_vs = VEC[i].vs; c5_vc = VEC[i].vc; c5_ft = VEC[i].ft;
         end
         for (int s = 0; s < 3 * LB; s++) strobe("R2 R3 R4 R5 R6 R7 R10 table");
      end

      // reset with a non-default program on the inputs: defaults apply (R1)
      c6_vs = 8'h1E; c6_vc = 8'h01; c6_ft = 8'h10;
      do_reset(1'b1);
      for (int s = 0; s < LB + 40; s++) strobe("R1 default program");

      // no strobe: flags hold (R9)
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         check("R9 hold without strobe");
      end

      // mid-field switch of standard and program (R8)
      while (m_cnt != 100) strobe("R8 pre-change");
      std_625 = 1'b0;
      c5_vs = 8'h02; c5_vc = 8'h09; c5_ft = 8'h06;
      c6_vs = 8'h07; c6_vc = 8'h03; c6_ft = 8'h01;
      for (int s = 0; s < 2 * LB; s++) strobe("R8 mid-field change");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule